// File: doc/BRIEF.md
# Interrupt Entry Stacking Sequencer

This block carries out the processor side of taking an interrupt on a 16-bit machine whose stack grows downward. The processor's register file stays outside the block. The block reads the current program counter, stack pointer, condition-code byte and global interrupt-enable flag from its inputs. It returns updates to those registers as one-cycle write strobes with data.

A request carries a vector number. The block accepts it only while idle and only if the enable flag is set, and it then clears the flag. On acceptance it samples the program counter, stack pointer and condition codes. Three word accesses follow on a simple memory bus with a ready handshake:

- a read of the vector-table slot at twice the vector number, which returns the handler address;
- a push of the program counter;
- a push of a word that holds the condition-code byte in both halves.

The last handshake loads the handler address into the program counter and pulses a done flag.

Top module: `irq_entry_seq`

## Requirements
- R1: While idle, a request is accepted only when `req_valid` and `ie_flag` are both high at a clock edge. One cycle after acceptance, `ie_clr` is high for exactly one cycle.
- R2: The first bus access starts in the cycle `ie_clr` is high. It is a read (`bus_we`=0) at byte address `{vector, 1'b0}`, that is, the vector number times two. The word returned on the accepting handshake becomes the handler address.
- R3: The second access writes the sampled program counter at the sampled stack pointer minus 2. Its handshake is followed one cycle later by `sp_we` carrying the sampled stack pointer minus 2.
- R4: The third access writes, at the sampled stack pointer minus 4, a word whose upper byte [15:8] and lower byte [7:0] both equal the sampled condition-code byte. Its handshake is followed one cycle later by `sp_we` carrying the sampled stack pointer minus 4.
- R5: In that same cycle, `pc_we` is high with `pc_wdata` equal to the handler address.
- R6: A bus access keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` unchanged until a clock edge where `bus_ready` is high. The sequence does not advance before that edge.
- R7: The program counter, stack pointer and condition codes that are stacked are the values present at acceptance. Later changes on `cur_pc`, `cur_sp` or `ccr_in` have no effect on the sequence.
- R8: `done` is high for exactly one cycle, the cycle of the program-counter load. The block is then idle. Requests seen while a sequence runs are ignored.
- R9: In the cycle after a clock edge with `rst` high, every output is zero.
- R10: A request while `ie_flag` is low starts no bus access and produces no register strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt request pending |
| req_vec | input | VEC_W | Vector number of the request |
| ie_flag | input | 1 | Global interrupt-enable flag from the register file |
| ccr_in | input | WORD_W/2 | Current condition-code byte |
| cur_pc | input | WORD_W | Current program counter |
| cur_sp | input | WORD_W | Current stack pointer |
| ie_clr | output | 1 | One-cycle strobe that clears the enable flag |
| sp_we | output | 1 | Stack-pointer write strobe |
| sp_wdata | output | WORD_W | New stack-pointer value |
| pc_we | output | 1 | Program-counter write strobe |
| pc_wdata | output | WORD_W | New program-counter value |
| done | output | 1 | One-cycle end-of-entry pulse |
| bus_req | output | 1 | Memory access request |
| bus_we | output | 1 | 1 = word write, 0 = word read |
| bus_addr | output | WORD_W | Byte address of the word |
| bus_wdata | output | WORD_W | Write data |
| bus_rdata | input | WORD_W | Read data, valid with `bus_ready` |
| bus_ready | input | 1 | Access completes at this edge |

## Verification
A wrong sequencer state shows on the bus in the very next cycle. It appears as a missing or extra `bus_req`, a read where a write belongs, or an address off by the stacking step. Every output is compared each clock against a behavioural model, so such a fault is caught within one cycle. Corrupted sampled values show up later, at the write that uses them. A bad pushed word is caught in the cycle its write begins. A bad handler address is caught when `pc_wdata` is strobed. A stack pointer that moved during the sequence, or a condition-code input changed mid-entry, would show as a displaced or altered pushed word.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  // Sequencer phases; order follows the bus access order.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VEC  = 2'd1,
    ST_PC   = 2'd2,
    ST_CCR  = 2'd3
  } seq_state_t;

  // Bytes moved per stack push.
  localparam int unsigned PUSH_BYTES = 2;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned VEC_W  = 6,
  localparam int unsigned CCR_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vec,
  input  logic              ie_flag,
  input  logic [CCR_W-1:0]  ccr_in,
  input  logic [WORD_W-1:0] cur_pc,
  input  logic [WORD_W-1:0] cur_sp,
  input  logic              bus_ready,
  input  logic [WORD_W-1:0] bus_rdata,
  output seq_state_t        state,
  output logic [VEC_W-1:0]  vec_q,
  output logic [WORD_W-1:0] pc_q,
  output logic [WORD_W-1:0] sp_q,
  output logic [CCR_W-1:0]  ccr_q,
  output logic              ie_clr,
  output logic              sp_we,
  output logic [WORD_W-1:0] sp_wdata,
  output logic              pc_we,
  output logic [WORD_W-1:0] pc_wdata,
  output logic              done
);

  localparam logic [WORD_W-1:0] STEP1 = WORD_W'(PUSH_BYTES);
  localparam logic [WORD_W-1:0] STEP2 = WORD_W'(2 * PUSH_BYTES);

  logic [WORD_W-1:0] hnd_q;
  logic              accept;

  assign accept = (state == ST_IDLE) && req_valid && ie_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      vec_q    <= '0;
      pc_q     <= '0;
      sp_q     <= '0;
      ccr_q    <= '0;
      hnd_q    <= '0;
      ie_clr   <= 1'b0;
      sp_we    <= 1'b0;
      sp_wdata <= '0;
      pc_we    <= 1'b0;
      pc_wdata <= '0;
      done     <= 1'b0;
    end else begin
      ie_clr <= 1'b0;
      sp_we  <= 1'b0;
      pc_we  <= 1'b0;
      done   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            vec_q  <= req_vec;
            pc_q   <= cur_pc;
            sp_q   <= cur_sp;
            ccr_q  <= ccr_in;
            ie_clr <= 1'b1;
            state  <= ST_VEC;
          end
        end
        ST_VEC: begin
          if (bus_ready) begin
            hnd_q <= bus_rdata;
            state <= ST_PC;
          end
        end
        ST_PC: begin
          if (bus_ready) begin
            sp_we    <= 1'b1;
            sp_wdata <= sp_q - STEP1;
            state    <= ST_CCR;
          end
        end
        ST_CCR: begin
          if (bus_ready) begin
            sp_we    <= 1'b1;
            sp_wdata <= sp_q - STEP2;
            pc_we    <= 1'b1;
            pc_wdata <= hnd_q;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_bus.sv
module irq_entry_bus
  import irq_entry_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned VEC_W  = 6,
  localparam int unsigned CCR_W = WORD_W / 2,
  localparam int unsigned PAD_W = WORD_W - VEC_W - 1
) (
  input  seq_state_t        state,
  input  logic [VEC_W-1:0]  vec_q,
  input  logic [WORD_W-1:0] pc_q,
  input  logic [WORD_W-1:0] sp_q,
  input  logic [CCR_W-1:0]  ccr_q,
  output logic              bus_req,
  output logic              bus_we,
  output logic [WORD_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata
);

  localparam logic [WORD_W-1:0] STEP1 = WORD_W'(PUSH_BYTES);
  localparam logic [WORD_W-1:0] STEP2 = WORD_W'(2 * PUSH_BYTES);

  logic [WORD_W-1:0] tbl_addr;
  assign tbl_addr = {{PAD_W{1'b0}}, vec_q, 1'b0};

  // Decoded from flopped state and flopped samples only: glitch-free.
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (state)
      ST_VEC: begin
        bus_req  = 1'b1;
        bus_addr = tbl_addr;
      end
      ST_PC: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = sp_q - STEP1;
        bus_wdata = pc_q;
      end
      ST_CCR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = sp_q - STEP2;
        bus_wdata = {ccr_q, ccr_q};
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned VEC_W  = 6,
  localparam int unsigned CCR_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vec,
  input  logic              ie_flag,
  input  logic [CCR_W-1:0]  ccr_in,
  input  logic [WORD_W-1:0] cur_pc,
  input  logic [WORD_W-1:0] cur_sp,
  output logic              ie_clr,
  output logic              sp_we,
  output logic [WORD_W-1:0] sp_wdata,
  output logic              pc_we,
  output logic [WORD_W-1:0] pc_wdata,
  output logic              done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [WORD_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_ready
);

  seq_state_t        state;
  logic [VEC_W-1:0]  vec_q;
  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] sp_q;
  logic [CCR_W-1:0]  ccr_q;

  irq_entry_ctrl #(.WORD_W(WORD_W), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vec(req_vec),
    .ie_flag(ie_flag), .ccr_in(ccr_in), .cur_pc(cur_pc), .cur_sp(cur_sp),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .state(state),
    .vec_q(vec_q), .pc_q(pc_q), .sp_q(sp_q), .ccr_q(ccr_q),
    .ie_clr(ie_clr), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .done(done)
  );

  irq_entry_bus #(.WORD_W(WORD_W), .VEC_W(VEC_W)) u_bus (
    .state(state), .vec_q(vec_q), .pc_q(pc_q), .sp_q(sp_q), .ccr_q(ccr_q),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata)
  );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned VEC_W  = 6,
  localparam int unsigned CCR_W = WORD_W / 2,
  localparam int unsigned PAD_W = WORD_W - VEC_W - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [VEC_W-1:0]  req_vec,
  input logic              ie_flag,
  input logic              ie_clr,
  input logic              sp_we,
  input logic              pc_we,
  input logic              done,
  input logic              bus_req,
  input logic              bus_we,
  input logic [WORD_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              bus_ready
);

  AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (rst)
    ie_clr |-> $past(req_valid && ie_flag)); // R1

  AST_VEC_READ: assert property (@(posedge clk) disable iff (rst)
    ie_clr |-> (bus_req && !bus_we &&
                bus_addr == {{PAD_W{1'b0}}, $past(req_vec), 1'b0})); // R2

  AST_SP_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    sp_we |-> $past(bus_req && bus_we && bus_ready)); // R3

  AST_CCR_BOTH_BYTES: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && $past(bus_req && bus_we && bus_ready))
      |-> (bus_wdata[WORD_W-1:CCR_W] == bus_wdata[CCR_W-1:0])); // R4

  AST_DONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    done |-> (pc_we && sp_we)); // R5

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) &&
      $stable(bus_addr) && $stable(bus_wdata))); // R6

  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !bus_req)); // R8

endmodule

bind irq_entry_seq irq_entry_chk #(.WORD_W(WORD_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vec(req_vec),
  .ie_flag(ie_flag), .ie_clr(ie_clr), .sp_we(sp_we), .pc_we(pc_we),
  .done(done), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ready(bus_ready)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 16;
  localparam int VEC_W  = 6;
  localparam int WDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [VEC_W-1:0] req_vec = '0;
  logic [7:0] ccr_in = '0;
  logic ie_r = 1'b0;
  logic [15:0] pc_r = '0, sp_r = '0;
  logic ie_clr, sp_we, pc_we, done, bus_req, bus_we;
  logic [15:0] sp_wdata, pc_wdata, bus_addr, bus_wdata, bus_rdata;
  logic bus_ready = 1'b0;

  logic [15:0] mem [0:1023];
  int lat = 0, wcnt = 0;
  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq #(.WORD_W(WORD_W), .VEC_W(VEC_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vec(req_vec),
    .ie_flag(ie_r), .ccr_in(ccr_in), .cur_pc(pc_r), .cur_sp(sp_r),
    .ie_clr(ie_clr), .sp_we(sp_we), .sp_wdata(sp_wdata), .pc_we(pc_we),
    .pc_wdata(pc_wdata), .done(done), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready)
  );

  assign bus_rdata = mem[bus_addr[10:1]];

  function automatic logic [15:0] handler_of(int v);
    return 16'hA000 ^ 16'(v * 16'h0105);
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Memory and register-file side (bench environment)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_req && bus_we && bus_ready) mem[bus_addr[10:1]] <= bus_wdata;
    if (ie_clr) ie_r <= 1'b0;
    if (sp_we)  sp_r <= sp_wdata;
    if (pc_we)  pc_r <= pc_wdata;
  end

  // Ready generator with per-access latency
  always @(negedge clk) begin
    if (bus_req && wcnt == lat) begin
      bus_ready <= 1'b1;
      wcnt = 0;
    end else begin
      bus_ready <= 1'b0;
      if (bus_req) wcnt++;
    end
  end

  // Behavioural reference model
  int m_ph = 0;
  int m_vec = 0;
  logic [15:0] m_pc, m_sp, m_hnd, e_spd, e_pcd;
  logic [7:0] m_ccr;
  bit e_ieclr, e_spwe, e_pcwe, e_done, m_rst;

  always @(posedge clk) begin
    e_ieclr = 0; e_spwe = 0; e_pcwe = 0; e_done = 0;
    m_rst = rst;
    if (rst) m_ph = 0;
    else case (m_ph)
      0: if (req_valid && ie_r) begin
           m_vec = int'(req_vec); m_pc = pc_r; m_sp = sp_r; m_ccr = ccr_in;
           e_ieclr = 1; m_ph = 1;
         end
      1: if (bus_ready) begin m_hnd = mem[m_vec]; m_ph = 2; end
      2: if (bus_ready) begin e_spwe = 1; e_spd = m_sp - 16'd2; m_ph = 3; end
      default: if (bus_ready) begin
           e_spwe = 1; e_spd = m_sp - 16'd4;
           e_pcwe = 1; e_pcd = m_hnd; e_done = 1; m_ph = 0;
         end
    endcase
  end

  always @(negedge clk) begin
    if (cyc > 0 && !finished) begin
      string t;
      logic [15:0] ea, ed;
      bit er, ew;
      t = m_rst ? "R9" : (m_ph == 1) ? "R2" : (m_ph == 2) ? "R3" :
          (m_ph == 3) ? "R4" : "R8";
      er = (m_ph != 0);
      ew = (m_ph >= 2);
      ea = (m_ph == 1) ? 16'(m_vec * 2) : (m_ph == 2) ? m_sp - 16'd2 :
           (m_ph == 3) ? m_sp - 16'd4 : 16'h0;
      ed = (m_ph == 2) ? m_pc : (m_ph == 3) ? {m_ccr, m_ccr} : 16'h0;
      chk(ie_clr == e_ieclr, m_rst ? "R9" : "R1 ie_clr", 16'(ie_clr), 16'(e_ieclr));
      chk(bus_req == er, {t, " R6 R10 bus_req"}, 16'(bus_req), 16'(er));
      chk(bus_we == ew, {t, " bus_we"}, 16'(bus_we), 16'(ew));
      chk(bus_addr == ea, {t, " R6 bus_addr"}, bus_addr, ea);
      chk(bus_wdata == ed, {t, " R7 bus_wdata"}, bus_wdata, ed);
      chk(sp_we == e_spwe, "R3 R4 sp_we", 16'(sp_we), 16'(e_spwe));
      if (e_spwe) chk(sp_wdata == e_spd, "R3 R4 sp_wdata", sp_wdata, e_spd);
      chk(pc_we == e_pcwe, "R5 pc_we", 16'(pc_we), 16'(e_pcwe));
      if (e_pcwe) chk(pc_wdata == e_pcd, "R5 pc_wdata", pc_wdata, e_pcd);
      chk(done == e_done, "R8 done", 16'(done), 16'(e_done));
    end
  end

  task automatic wait_done();
    int n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 200);
  endtask

  // Full entry, with ccr_in disturbed during the sequence (R7)
  task automatic run(int v, int l, logic [7:0] cc, logic [15:0] pc0, logic [15:0] sp0);
    @(negedge clk);
    lat = l; pc_r = pc0; sp_r = sp0; ie_r = 1'b1;
    req_valid = 1'b1; req_vec = VEC_W'(v); ccr_in = cc;
    @(negedge clk);
    req_valid = 1'b0; ccr_in = ~cc;
    wait_done();
    @(negedge clk);
    chk(mem[(sp0 - 16'd2) >> 1] == pc0, "R3 stacked pc", mem[(sp0 - 16'd2) >> 1], pc0);
    chk(mem[(sp0 - 16'd4) >> 1] == {cc, cc}, "R4 R7 stacked ccr",
        mem[(sp0 - 16'd4) >> 1], {cc, cc});
    chk(pc_r == handler_of(v), "R2 R5 pc loaded", pc_r, handler_of(v));
    chk(sp_r == sp0 - 16'd4, "R4 final sp", sp_r, sp0 - 16'd4);
    chk(ie_r == 1'b0, "R1 enable cleared", 16'(ie_r), 16'h0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (i < 64) ? handler_of(i) : 16'h0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !ie_clr && !done && !sp_we && !pc_we, "R9 reset outputs",
        {11'h0, bus_req, ie_clr, done, sp_we, pc_we}, 16'h0);
    rst = 1'b0;
    // R10: request with enable low
    pc_r = 16'h1234; sp_r = 16'h0700; ie_r = 1'b0;
    req_valid = 1'b1; req_vec = 6'd9; ccr_in = 8'h5A;
    repeat (5) @(negedge clk);
    chk(bus_req == 1'b0, "R10 no access", 16'(bus_req), 16'h0);
    chk(sp_r == 16'h0700, "R10 sp untouched", sp_r, 16'h0700);
    req_valid = 1'b0;
    run(5, 0, 8'hC3, 16'h2468, 16'h0600);
    run(0, 3, 8'h01, 16'hFFFE, 16'h0680);
    run(63, 2, 8'h80, 16'h0002, 16'h0604);
    run(17, 5, 8'hFF, 16'h8001, 16'h07F0);
    // R8: request held high; busy and enable-low cycles must not re-accept
    @(negedge clk);
    lat = 1; ie_r = 1'b1; req_valid = 1'b1; req_vec = 6'd33;
    sp_r = 16'h0500; ccr_in = 8'h3C;
    wait_done();
    repeat (4) @(negedge clk);
    chk(bus_req == 1'b0, "R8 idle after done", 16'(bus_req), 16'h0);
    ie_r = 1'b1; req_vec = 6'd34;
    wait_done();
    @(negedge clk);
    chk(pc_r == handler_of(34), "R8 second entry", pc_r, handler_of(34));
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (cyc >= WDOG && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule